// File: doc/BRIEF.md
# Phase-Shifted Unipolar PWM Generator

This block produces the switching commands for a chain of series-connected H-bridge cells that together form one phase of a cascaded multilevel converter. Each cell has its own symmetric triangular carrier. The carriers of the cells are spread evenly over one carrier period, so the switching events of the cells interleave and the summed staircase voltage has little carrier-frequency content.

Every cell compares its carrier with a signed reference sample to drive its first leg. It compares the same carrier with the negated reference to drive its second leg, which gives unipolar modulation. The carrier half-period is set in clock cycles, so the switching frequency is the clock frequency divided by twice that setting. A new setting is taken up only at a carrier valley, so no pulse in progress is cut short. A per-cell bypass flag holds both legs of a removed cell low while the other cells keep switching.

Top module: `pspwm_gen`

## Requirements
- R1: While `rst` is high every leg output is low. The carrier phase restarts at zero, and `period_in` is sampled as the active half-period.
- R2: With half-period P, each carrier counts 0,1,…,P and then back down through P-1,…,1, so one carrier period is 2P clocks. Over any 2P consecutive clocks with a constant reference r, `leg_pos[i]` is high for 0 cycles if r ≤ 0, for 2r−1 cycles if 1 ≤ r ≤ P, and for 2P cycles if r > P. The output is high whenever r is strictly greater than the carrier.
- R3: `leg_neg[i]` follows the rule of R2 with −r in place of r.
- R4: The carrier of cell i is ahead of the carrier of cell 0 by floor(i·2P/N) clocks. Cell 0 reaches its valley at the first clock after reset. Bit i of each output bus belongs to cell i.
- R5: `leg_pos[i]` and `leg_neg[i]` are never high in the same cycle.
- R6: When `bypass_in[i]` is high at a clock edge, both legs of cell i are low after that edge. When it is low, the cell's legs follow R2 and R3 from the next edge.
- R7: A new `period_in` takes effect only when the carrier of cell 0 returns to its valley. The carrier period that is running when the setting changes completes at its old length.
- R8: A `period_in` of 0 is treated as a half-period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | REF_W | Signed reference sample, in carrier counts |
| period_in | input | CNT_W | Carrier half-period in clocks |
| bypass_in | input | N_CELLS | Per-cell bypass flags, bit i for cell i |
| leg_pos | output | N_CELLS | First-leg commands, compared with +reference |
| leg_neg | output | N_CELLS | Second-leg commands, compared with −reference |

## Verification
The assertions assume a clock that is running and a reset that is applied before the first result matters. They place no limit on the reference: any signed value, including the most negative one, keeps the two legs exclusive because the negation is done one bit wider. The period setting must fit in CNT_W bits, and a setting of 0 is clamped inside the block, so any input value is legal. The stimulus loads each period setting through reset, or changes it in the middle of a carrier period. It holds the reference steady over each full carrier window it counts, so that duty counts do not depend on the cell offsets.

// File: rtl/pspwm_pkg.sv
package pspwm_pkg;

  // Direction of a triangular carrier at a given phase
  typedef enum logic {
    SLOPE_UP   = 1'b0,
    SLOPE_DOWN = 1'b1
  } slope_e;

endpackage

// File: rtl/pspwm_phase.sv
// Shared phase counter, period latch and per-cell phase offsets.
module pspwm_phase #(
  parameter int N_CELLS = 5,
  parameter int CNT_W   = 12,
  parameter int PH_W    = CNT_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CNT_W-1:0]              period_in,
  output logic [PH_W-1:0]               ph_o,
  output logic [CNT_W-1:0]              per_o,
  output logic [PH_W-1:0]               two_p_o,
  output logic [N_CELLS-1:0][PH_W-1:0]  off_o
);

  localparam int MUL_W = PH_W + $clog2(N_CELLS + 1);

  logic [CNT_W-1:0]             per_eff;
  logic [PH_W-1:0]              two_p_eff;
  logic [N_CELLS-1:0][PH_W-1:0] off_next;
  logic [PH_W-1:0]              ph_q;
  logic [CNT_W-1:0]             per_q;
  logic [N_CELLS-1:0][PH_W-1:0] off_q;
  logic [PH_W-1:0]              two_p_q;
  logic                         wrap;

  // A zero setting would stall the carrier; clamp it to one count
  assign per_eff   = (period_in == '0) ? CNT_W'(1) : period_in;
  assign two_p_eff = {per_eff, 1'b0};
  assign two_p_q   = {per_q, 1'b0};
  assign wrap      = (ph_q == two_p_q - PH_W'(1));

  // Offset of cell i: floor(i * 2P / N)
  for (genvar i = 0; i < N_CELLS; i++) begin : g_off
    logic [MUL_W-1:0] prod;
    assign prod        = MUL_W'(i) * MUL_W'(two_p_eff);
    assign off_next[i] = PH_W'(prod / MUL_W'(N_CELLS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      per_q <= per_eff;
      off_q <= off_next;
    end else if (wrap) begin
      ph_q  <= '0;
      per_q <= per_eff;
      off_q <= off_next;
    end else begin
      ph_q <= ph_q + PH_W'(1);
    end
  end

  assign ph_o    = ph_q;
  assign per_o   = per_q;
  assign two_p_o = two_p_q;
  assign off_o   = off_q;

  // The active period may only move when the phase has just returned to zero
  assert_period_valley_R7: assert property (@(posedge clk) disable iff (rst)
    (ph_q != '0) |-> $stable(per_q))
    else $error("period changed away from valley");

  // Phase stays inside one carrier period
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    ph_q < two_p_q)
    else $error("phase out of range");

endmodule

// File: rtl/pspwm_cell.sv
// One cell: offset carrier and unipolar comparison of both legs.
module pspwm_cell #(
  parameter int CNT_W = 12,
  parameter int REF_W = 13,
  parameter int PH_W  = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         ph,
  input  logic [PH_W-1:0]         off,
  input  logic [CNT_W-1:0]        per,
  input  logic [PH_W-1:0]         two_p,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic                    byp,
  output logic                    leg_pos,
  output logic                    leg_neg
);
  import pspwm_pkg::*;

  localparam int CMP_W = ((REF_W > CNT_W) ? REF_W : CNT_W) + 2;

  logic [PH_W:0]              sum;
  logic [PH_W-1:0]            phase;
  slope_e                     slope;
  logic [CNT_W-1:0]           car;
  logic signed [CMP_W-1:0]    ref_x;
  logic signed [CMP_W-1:0]    neg_x;
  logic signed [CMP_W-1:0]    car_x;
  logic                       pos_d;
  logic                       neg_d;

  assign sum   = {1'b0, ph} + {1'b0, off};
  assign phase = (sum >= {1'b0, two_p}) ? PH_W'(sum - {1'b0, two_p}) : sum[PH_W-1:0];
  assign slope = (phase <= {1'b0, per}) ? SLOPE_UP : SLOPE_DOWN;
  assign car   = (slope == SLOPE_UP) ? phase[CNT_W-1:0] : CNT_W'(two_p - phase);

  // Widened so that negating the most negative reference cannot wrap
  assign ref_x = CMP_W'(ref_in);
  assign neg_x = -ref_x;
  assign car_x = signed'({{(CMP_W-CNT_W){1'b0}}, car});

  assign pos_d = !byp && (ref_x > car_x);
  assign neg_d = !byp && (neg_x > car_x);

  always_ff @(posedge clk) begin
    if (rst) begin
      leg_pos <= 1'b0;
      leg_neg <= 1'b0;
    end else begin
      leg_pos <= pos_d;
      leg_neg <= neg_d;
    end
  end

  assert_carrier_range_R2: assert property (@(posedge clk) disable iff (rst)
    car <= per)
    else $error("carrier above peak");

  assert_no_shoot_through_R5: assert property (@(posedge clk) disable iff (rst)
    !(leg_pos && leg_neg))
    else $error("both legs high");

  assert_bypass_low_R6: assert property (@(posedge clk) disable iff (rst)
    $past(byp) |-> (!leg_pos && !leg_neg))
    else $error("bypassed cell switching");

endmodule

// File: rtl/pspwm_gen.sv
// Phase-shifted unipolar PWM for N series H-bridge cells of one phase.
module pspwm_gen #(
  parameter int N_CELLS = 5,
  parameter int CNT_W   = 12,
  parameter int REF_W   = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [CNT_W-1:0]        period_in,
  input  logic [N_CELLS-1:0]      bypass_in,
  output logic [N_CELLS-1:0]      leg_pos,
  output logic [N_CELLS-1:0]      leg_neg
);

  localparam int PH_W = CNT_W + 1;

  logic [PH_W-1:0]              ph;
  logic [CNT_W-1:0]             per;
  logic [PH_W-1:0]              two_p;
  logic [N_CELLS-1:0][PH_W-1:0] off;

  pspwm_phase #(
    .N_CELLS (N_CELLS),
    .CNT_W   (CNT_W),
    .PH_W    (PH_W)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .period_in (period_in),
    .ph_o      (ph),
    .per_o     (per),
    .two_p_o   (two_p),
    .off_o     (off)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    pspwm_cell #(
      .CNT_W (CNT_W),
      .REF_W (REF_W),
      .PH_W  (PH_W)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .ph      (ph),
      .off     (off[i]),
      .per     (per),
      .two_p   (two_p),
      .ref_in  (ref_in),
      .byp     (bypass_in[i]),
      .leg_pos (leg_pos[i]),
      .leg_neg (leg_neg[i])
    );
  end

  // While reset is held the outputs must stay quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (leg_pos == '0 && leg_neg == '0))
    else $error("outputs active after reset edge");

endmodule

// File: tb/pspwm_gen_tb.sv
module pspwm_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 5;
  localparam int CW    = 12;
  localparam int RW    = 13;
  localparam int NVEC  = 10;
  // {reference, half-period}
  localparam int VEC [NVEC][2] = '{
    '{  0, 10}, '{  3, 10}, '{ -3, 10}, '{ 10, 10}, '{ 11, 10},
    '{-11, 10}, '{  5,  6}, '{ -7,  8}, '{  1,  0}, '{  2,  0}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [RW-1:0] ref_in = '0;
  logic [CW-1:0]        period_in = CW'(10);
  logic [N-1:0]         bypass_in = '0;
  logic [N-1:0]         leg_pos;
  logic [N-1:0]         leg_neg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pspwm_gen #(.N_CELLS(N), .CNT_W(CW), .REF_W(RW)) u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .period_in(period_in),
    .bypass_in(bypass_in), .leg_pos(leg_pos), .leg_neg(leg_neg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_cnt(int r, int p);
    int pe = (p == 0) ? 1 : p;
    if (r <= 0) return 0;
    if (r > pe) return 2 * pe;
    return 2 * r - 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(int per);
    @(negedge clk);
    rst = 1'b1;
    period_in = CW'(per);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pos_c [N];
    int neg_c [N];
    int both;
    int first [N];
    int pt [4];
    int np;

    // R1: outputs stay low during reset, even with a large reference
    ref_in = RW'(50);
    repeat (4) tick();
    check("R1 pos in reset", int'(leg_pos), 0);
    check("R1 neg in reset", int'(leg_neg), 0);

    // R2/R3/R8: duty counts over one full carrier period, table driven
    for (int v = 0; v < NVEC; v++) begin
      int pe;
      pe = (VEC[v][1] == 0) ? 1 : VEC[v][1];
      ref_in = RW'(VEC[v][0]);
      do_reset(VEC[v][1]);
      repeat (3) tick();
      for (int c = 0; c < N; c++) begin pos_c[c] = 0; neg_c[c] = 0; end
      both = 0;
      for (int t = 0; t < 2 * pe; t++) begin
        tick();
        for (int c = 0; c < N; c++) begin
          pos_c[c] += int'(leg_pos[c]);
          neg_c[c] += int'(leg_neg[c]);
          if (leg_pos[c] && leg_neg[c]) both++;
        end
      end
      for (int c = 0; c < N; c++) begin
        check((VEC[v][1] == 0) ? "R8 pos clamp" : "R2 pos duty", pos_c[c],
              exp_cnt(VEC[v][0], VEC[v][1]));
        check((VEC[v][1] == 0) ? "R8 neg clamp" : "R3 neg duty", neg_c[c],
              exp_cnt(-VEC[v][0], VEC[v][1]));
      end
      check("R5 exclusive legs", both, 0);
    end

    // R4: carrier stagger, P=10 gives offsets 0,4,8,12,16
    ref_in = RW'(1);
    do_reset(10);
    for (int c = 0; c < N; c++) first[c] = -1;
    for (int t = 0; t < 40; t++) begin
      tick();
      for (int c = 0; c < N; c++)
        if (leg_pos[c] && first[c] < 0) first[c] = t;
    end
    for (int c = 0; c < N; c++)
      check("R4 phase offset", ((first[c] - first[0]) % 20 + 20) % 20,
            (20 - (c * 20) / N) % 20);

    // R7: period change applied only at cell 0 valley
    ref_in = RW'(1);
    do_reset(10);
    np = 0;
    for (int t = 0; t < 80; t++) begin
      tick();
      if (leg_pos[0] && np < 4) begin pt[np] = t; np++; end
      if (np == 1 && t == pt[0] + 3) period_in = CW'(6);
    end
    check("R7 pulses seen", np, 4);
    check("R7 old period completes", pt[1] - pt[0], 20);
    check("R7 new period used", pt[2] - pt[1], 12);

    // R6: bypass cell 2
    bypass_in = 5'b00100;
    ref_in = RW'(9);
    do_reset(8);
    repeat (3) tick();
    for (int c = 0; c < N; c++) begin pos_c[c] = 0; neg_c[c] = 0; end
    for (int t = 0; t < 16; t++) begin
      tick();
      for (int c = 0; c < N; c++) pos_c[c] += int'(leg_pos[c]);
    end
    for (int c = 0; c < N; c++)
      check("R6 bypass pos", pos_c[c], (c == 2) ? 0 : 16);
    ref_in = RW'(-9);
    repeat (2) tick();
    for (int t = 0; t < 16; t++) begin
      tick();
      for (int c = 0; c < N; c++) neg_c[c] += int'(leg_neg[c]);
    end
    for (int c = 0; c < N; c++)
      check("R6 bypass neg", neg_c[c], (c == 2) ? 0 : 16);
    bypass_in = '0;
    tick();
    check("R6 release next edge", int'(leg_neg[2]), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule